// File: doc/BRIEF.md
# SPI Command Buffer Slave

This block is an SPI slave that gives a host processor access to a 1024-byte on-chip data buffer. The host frames every transaction with an active-low chip select. The first byte of a frame is a command. The command picks one of three actions: return a fixed identifier, fill the buffer, or stream the buffer back out. Every frame has a fixed layout. A data frame carries two header bytes between the command and the payload. Read data and the identifier only appear from byte index 4 of the frame onward. The bytes before that are dummy cycles, and they give the slave time to fetch from memory.

The SPI pins are sampled in the system clock domain through synchronizers, and the bit engine works on the detected clock edges. For this reason the system clock must be well above the SPI clock. The SCLK high phase must last at least 3 system clock periods, and the low phase at least 5. The buffer is a simple dual-port memory with a synchronous read, written so that block RAM can be inferred.

Top module: `spi_cmd_buffer`

## Requirements
- R1: The bus runs in SPI mode 3 with the most significant bit first. SCLK idles high. MOSI is captured on each rising SCLK edge. MISO changes only after a falling SCLK edge and holds through the following rising edge.
- R2: In a frame whose command byte is 0x01, byte index 4 on MISO carries the identifier ID_VALUE (default 0x01). Every other byte of that frame returns 0x00.
- R3: In a frame whose command byte is 0x04, bytes 1 and 2 are discarded. Byte index 3+k, for k from 0 to 1023, is stored at buffer address k.
- R4: In a write frame, bytes after the last payload byte (byte index 1027 onward) are not stored.
- R5: In a frame whose command byte is 0x07, bytes 0 to 3 return 0x00. Byte index 4+k returns the buffer content at address k mod 1024, so the address wraps from 1023 to 0.
- R6: Command values 0x02, 0x03, 0x05, 0x06 and any value other than 0x01, 0x04 and 0x07 return 0x00 for the whole frame and leave the buffer unchanged.
- R7: Raising chip select aborts a partially shifted byte. The next frame starts with a fresh bit count and byte count, and its first byte is decoded as a command.
- R8: MISO is 0 during reset and whenever chip select is high.
- R9: A write frame that ends early updates only the addresses of the payload bytes actually sent. The other addresses keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | SPI serial clock from the host, idles high |
| cs_n | input | 1 | Active-low chip select that bounds a frame |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host, registered |

## Verification
The bench first fills the whole buffer with a byte pattern. It then reads the buffer back one byte past its end. A slave that stored the trailing dummy byte would corrupt address 0. One that did not wrap its read pointer would return the last byte instead of the first. A table of command codes shows that only the identifier command answers and that the no-op codes write nothing. A frame that is cut off after a few bits must not shift the framing of the next frame, or the identifier would arrive misaligned. A short write must touch only the addresses it actually sends.

// File: rtl/scb_pkg.sv
package scb_pkg;
  localparam logic [7:0] CMD_ID    = 8'h01;
  localparam logic [7:0] CMD_WDATA = 8'h04;
  localparam logic [7:0] CMD_RDATA = 8'h07;

  // byte index of the first payload byte in a write frame
  localparam int WR_HDR = 3;
  // byte index of the first returned byte in read and ID frames
  localparam int RD_HDR = 4;

  typedef enum logic [1:0] {
    M_NONE,
    M_ID,
    M_WR,
    M_RD
  } mode_e;
endpackage

// File: rtl/scb_sync.sv
module scb_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage[0] <= RST_VAL;
    else     stage[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[i] <= RST_VAL;
      else     stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/scb_bitio.sv
module scb_bitio #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              cs_s,
  input  logic              mosi_s,
  input  logic [DATA_W-1:0] tx_byte,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_done,
  output logic [$clog2(DATA_W)-1:0] bit_cnt,
  output logic              miso
);
  localparam int BC_W = $clog2(DATA_W);
  localparam logic [BC_W-1:0] LAST_BIT = BC_W'(DATA_W - 1);

  logic              sclk_d;
  logic              rise, fall;
  logic [DATA_W-1:0] rx_sh;
  logic [DATA_W-1:0] tx_sh;

  assign rise    = sclk_s & ~sclk_d & ~cs_s;
  assign fall    = ~sclk_s & sclk_d & ~cs_s;
  assign rx_byte = {rx_sh[DATA_W-2:0], mosi_s};
  assign rx_done = rise && (bit_cnt == LAST_BIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d  <= 1'b1;
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      miso    <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      if (cs_s) begin
        bit_cnt <= '0;
        tx_sh   <= '0;
        miso    <= 1'b0;
      end else begin
        if (rise) begin
          rx_sh   <= rx_byte;
          bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
        end
        if (fall) begin
          if (bit_cnt == '0) begin
            miso  <= tx_byte[DATA_W-1];
            tx_sh <= {tx_byte[DATA_W-2:0], 1'b0};
          end else begin
            miso  <= tx_sh[DATA_W-1];
            tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/scb_ram.sv
module scb_ram #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/scb_ctrl.sv
module scb_ctrl
  import scb_pkg::*;
#(
  parameter int          ADDR_W   = 10,
  parameter int          DATA_W   = 8,
  parameter logic [7:0]  ID_VALUE = 8'h01
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_s,
  input  logic              rx_done,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic [DATA_W-1:0] ram_q,
  output logic [DATA_W-1:0] tx_byte,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic [ADDR_W-1:0] raddr,
  output logic [ADDR_W+1:0] byte_idx
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = ADDR_W + 2;
  localparam logic [CNT_W-1:0] WR_FIRST = CNT_W'(WR_HDR);
  localparam logic [CNT_W-1:0] WR_LAST  = CNT_W'(WR_HDR + DEPTH - 1);
  localparam logic [CNT_W-1:0] RD_FIRST = CNT_W'(RD_HDR);

  mode_e mode;

  function automatic mode_e decode(input logic [7:0] c);
    case (c)
      CMD_ID:    decode = M_ID;
      CMD_WDATA: decode = M_WR;
      CMD_RDATA: decode = M_RD;
      default:   decode = M_NONE;
    endcase
  endfunction

  assign we = rx_done && (mode == M_WR) &&
              (byte_idx >= WR_FIRST) && (byte_idx <= WR_LAST);

  always_ff @(posedge clk) begin
    if (rst || cs_s) begin
      mode     <= M_NONE;
      byte_idx <= '0;
      waddr    <= '0;
      raddr    <= '0;
    end else if (rx_done) begin
      if (byte_idx != '1) byte_idx <= byte_idx + 1'b1;
      if (byte_idx == '0) mode <= decode(rx_byte[7:0]);
      if (we) waddr <= waddr + 1'b1;
      if (mode == M_RD && byte_idx >= RD_FIRST) raddr <= raddr + 1'b1;
    end
  end

  always_comb begin
    tx_byte = '0;
    case (mode)
      M_ID: if (byte_idx == RD_FIRST) tx_byte = DATA_W'(ID_VALUE);
      M_RD: if (byte_idx >= RD_FIRST) tx_byte = ram_q;
      default: tx_byte = '0;
    endcase
  end
endmodule

// File: rtl/spi_cmd_buffer.sv
module spi_cmd_buffer #(
  parameter int         ADDR_W      = 10,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] ID_VALUE    = 8'h01
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic miso
);
  localparam int DATA_W = 8;
  localparam int BC_W   = $clog2(DATA_W);

  logic              sclk_s, cs_s, mosi_s;
  logic [DATA_W-1:0] rx_byte, tx_byte, ram_q;
  logic              rx_done, ram_we;
  logic [BC_W-1:0]   bit_cnt;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [ADDR_W+1:0] byte_idx;

  scb_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({sclk, cs_n, mosi}),
    .q   ({sclk_s, cs_s, mosi_s})
  );

  scb_bitio #(.DATA_W(DATA_W)) u_bitio (
    .clk     (clk),
    .rst     (rst),
    .sclk_s  (sclk_s),
    .cs_s    (cs_s),
    .mosi_s  (mosi_s),
    .tx_byte (tx_byte),
    .rx_byte (rx_byte),
    .rx_done (rx_done),
    .bit_cnt (bit_cnt),
    .miso    (miso)
  );

  scb_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_VALUE(ID_VALUE)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .cs_s     (cs_s),
    .rx_done  (rx_done),
    .rx_byte  (rx_byte),
    .ram_q    (ram_q),
    .tx_byte  (tx_byte),
    .we       (ram_we),
    .waddr    (waddr),
    .raddr    (raddr),
    .byte_idx (byte_idx)
  );

  scb_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (waddr),
    .wdata (rx_byte),
    .raddr (raddr),
    .rdata (ram_q)
  );
endmodule

// File: rtl/scb_checker.sv
module scb_checker #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_s,
  input logic              sclk_s,
  input logic              miso,
  input logic              we,
  input logic [2:0]        bit_cnt,
  input logic [ADDR_W+1:0] byte_idx
);
  // R8: deselected slave drives zero
  a_r8_miso_idle: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> (miso == 1'b0));

  // R1: MISO only moves after a falling edge, never while SCLK is high
  a_r1_miso_hold_high: assert property (@(posedge clk) disable iff (rst)
    ($past(sclk_s) && !$past(cs_s)) |-> $stable(miso));

  // R7: counters are cleared while the frame is closed
  a_r7_idle_counters: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> (byte_idx == '0 && bit_cnt == 3'd0));

  // R6: no buffer write outside an open frame
  a_r6_write_in_frame: assert property (@(posedge clk) disable iff (rst)
    we |-> !cs_s);

  // R3: a stored byte always closes a whole byte
  a_r3_write_ends_byte: assert property (@(posedge clk) disable iff (rst)
    we |=> (bit_cnt == 3'd0));
endmodule

bind spi_cmd_buffer scb_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cs_s     (cs_s),
  .sclk_s   (sclk_s),
  .miso     (miso),
  .we       (ram_we),
  .bit_cnt  (bit_cnt),
  .byte_idx (byte_idx)
);

// File: tb/spi_cmd_buffer_test.sv
module spi_cmd_buffer_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 1024;
  localparam int LOW_CLKS   = 5;
  localparam int HIGH_CLKS  = 3;
  localparam int WATCHDOG   = 195000;

  // {command, expected byte at index 4}
  localparam logic [15:0] VEC [0:6] = '{
    16'h0101, 16'h0200, 16'h0300, 16'h0500, 16'h0600, 16'hA500, 16'h0000
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b1;
  logic cs_n = 1'b1;
  logic mosi = 1'b0;
  logic miso;

  int n_checks = 0;
  int n_err    = 0;
  bit done     = 0;

  logic [7:0] txbuf [0:1039];
  logic [7:0] rxbuf [0:1039];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_cmd_buffer uut (
    .clk  (clk),
    .rst  (rst),
    .sclk (sclk),
    .cs_n (cs_n),
    .mosi (mosi),
    .miso (miso)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic spi_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = '0;
    for (int b = 7; b > 7 - nbits; b--) begin
      sclk = 1'b0;
      mosi = tx[b];
      repeat (LOW_CLKS) @(negedge clk);
      rx[b] = miso;
      sclk = 1'b1;
      repeat (HIGH_CLKS) @(negedge clk);
    end
  endtask

  task automatic run_frame(input int len);
    logic [7:0] r;
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < len; i++) begin
      spi_bits(txbuf[i], 8, r);
      rxbuf[i] = r;
    end
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (4) @(negedge clk);
    check("R8 reset", {7'd0, miso}, 8'h00);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check("R8 idle", {7'd0, miso}, 8'h00);

    // R3/R4: full write frame with nonzero trailing dummy
    txbuf[0] = 8'h04; txbuf[1] = 8'hFF; txbuf[2] = 8'hFF;
    for (int i = 0; i < DEPTH; i++) txbuf[3 + i] = 8'(i % 256);
    txbuf[DEPTH + 3] = 8'hEE;
    run_frame(DEPTH + 4);
    check("R8 after frame", {7'd0, miso}, 8'h00);

    // R2/R6: command table, payload bytes that must not be stored
    for (int v = 0; v < 7; v++) begin
      txbuf[0] = VEC[v][15:8];
      for (int i = 1; i < 8; i++) txbuf[i] = 8'h5A;
      run_frame(8);
      for (int i = 0; i < 8; i++)
        check(i == 4 ? "R2/R6 byte4" : "R2/R6 zero", rxbuf[i],
              i == 4 ? VEC[v][7:0] : 8'h00);
    end

    // R5/R1: full read with one wrapped byte
    txbuf[0] = 8'h07;
    for (int i = 1; i < DEPTH + 5; i++) txbuf[i] = 8'h00;
    run_frame(DEPTH + 5);
    for (int i = 0; i < 4; i++) check("R5 dummy", rxbuf[i], 8'h00);
    check("R4 dummy not stored", rxbuf[4], 8'h00);
    for (int i = 0; i < DEPTH; i++) check("R3/R6/R1 data", rxbuf[4 + i], 8'(i % 256));
    check("R5 wrap", rxbuf[DEPTH + 4], 8'h00);

    // R7: aborted partial byte, then an ID frame
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    spi_bits(8'h04, 3, r);
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R8 after abort", {7'd0, miso}, 8'h00);
    txbuf[0] = 8'h01;
    for (int i = 1; i < 5; i++) txbuf[i] = 8'h00;
    run_frame(5);
    check("R7 id after abort", rxbuf[4], 8'h01);

    // R9: short write, then read the start of the buffer
    txbuf[0] = 8'h04; txbuf[1] = 8'h00; txbuf[2] = 8'h00;
    txbuf[3] = 8'hAA; txbuf[4] = 8'hBB;
    run_frame(5);
    txbuf[0] = 8'h07;
    for (int i = 1; i < 8; i++) txbuf[i] = 8'h00;
    run_frame(8);
    check("R9 addr0", rxbuf[4], 8'hAA);
    check("R9 addr1", rxbuf[5], 8'hBB);
    check("R9 addr2 kept", rxbuf[6], 8'h02);
    check("R9 addr3 kept", rxbuf[7], 8'h03);

    done = 1;
    summary();
    $finish;
  end
endmodule